// File: doc/BRIEF.md
# Warp Load Line Splitter

This block turns one warp-wide load into the minimal series of aligned memory requests that serve it. A request carries an address per lane for 32 lanes, a mask of active lanes, a word size, a cacheability mode and a volatile flag. The block finds every distinct aligned unit that any active lane touches. It then emits one request per unit, each carrying the aligned address, the unit size in bytes and the mask of lanes served by it.

The cacheability mode is chosen per incoming request. In full-caching mode each unit is a 128-byte line. In L2-only mode each unit is a 32-byte sector, which trims overfetch when lanes scatter. Lanes may touch words in any order, and several lanes may hit the same word, so each unit is fetched only once. Once the last unit has been handed off, the block raises a one-cycle done pulse together with the number of requests emitted. A testbench or a performance monitor can compare that count against the expected overfetch.

Top module: `warp_line_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, out_valid_o is 0 and done_o is 0.
- R2: With req_l2only_i = 0, every emitted request has an address that is a multiple of 128 and out_bytes_o = 128.
- R3: With req_l2only_i = 1, every emitted request has an address that is a multiple of 32 and out_bytes_o = 32.
- R4: Each aligned unit touched by at least one active lane is emitted exactly once, whatever the lane order and however many lanes share a word. Its out_lanes_o has bit i set exactly when active lane i touches that unit.
- R5: The mode bit is captured with each request, so back-to-back requests may use different unit sizes.
- R6: out_refetch_o equals the req_volatile_i captured with the request, on every request that request emits.
- R7: Requests are emitted in ascending order of the lowest-indexed lane whose bytes they hold. For a lane that spans two units, its lower unit comes first.
- R8: A word whose bytes [addr, addr + bytes - 1] cross a unit boundary makes the lane appear in the masks of both units.
- R9: Lanes whose req_mask_i bit is 0 are ignored. A request with an all-zero mask emits nothing and still signals done, with a count of 0.
- R10: done_o is high for exactly one cycle after the last request handshake, with done_count_o equal to the number of requests emitted for that warp.
- R11: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_addr_o, out_lanes_o and out_bytes_o hold in the next cycle.
- R12: req_size_i is a log2 byte code: 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 bytes, and larger codes act as 4. req_ready_o is 0 from acceptance until done_o has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request offered |
| req_ready_o | output | 1 | Splitter idle and able to take a request |
| req_addr_i | input | NUM_LANES*ADDR_W | Byte address per lane, lane 0 in the low bits |
| req_mask_i | input | NUM_LANES | Active lanes |
| req_size_i | input | 3 | log2 of word size in bytes |
| req_l2only_i | input | 1 | 1 = 32-byte sectors, 0 = 128-byte lines |
| req_volatile_i | input | 1 | Force refetch on all emitted requests |
| out_valid_o | output | 1 | Memory request valid |
| out_ready_i | input | 1 | Memory side takes the request |
| out_addr_o | output | ADDR_W | Aligned unit address |
| out_bytes_o | output | 8 | Unit size in bytes (32 or 128) |
| out_lanes_o | output | NUM_LANES | Lanes served by this request |
| out_refetch_o | output | 1 | Bypass cached data |
| done_o | output | 1 | One-cycle pulse at end of warp |
| done_count_o | output | CNT_W | Requests emitted for the warp |

## Verification
The main function is driven with unit-stride lanes in both modes, which tells line granularity apart from sector granularity: the same footprint gives one request in one mode and four in the other. Reversed lane order and all lanes hitting one word show that order and duplicates do not add requests. A large stride with half the lanes masked separates real per-lane splitting from mask handling. Boundary-crossing words of several sizes confirm that a lane lands in two masks and that its lower unit comes first, and a toggling ready checks the hold behaviour against the same expected sequence.

// File: rtl/wls_pkg.sv
package wls_pkg;
  localparam int LINE_SHIFT   = 7;
  localparam int SECTOR_SHIFT = 5;
  localparam int MAX_SIZE_LOG = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } wls_state_e;
endpackage

// File: rtl/wls_lane_span.sv
module wls_lane_span #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              l2only_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  import wls_pkg::*;

  logic [2:0]        size_c;
  logic [ADDR_W-1:0] last_byte;
  logic [ADDR_W-1:0] unit_mask;

  always_comb begin
    size_c    = (size_i > 3'(MAX_SIZE_LOG)) ? 3'(MAX_SIZE_LOG) : size_i;
    last_byte = addr_i + ((ADDR_W'(1) << size_c) - ADDR_W'(1));
    unit_mask = l2only_i ? ((ADDR_W'(1) << SECTOR_SHIFT) - ADDR_W'(1))
                         : ((ADDR_W'(1) << LINE_SHIFT) - ADDR_W'(1));
    lo_o      = addr_i & ~unit_mask;
    hi_o      = last_byte & ~unit_mask;
  end
endmodule

// File: rtl/wls_first_pend.sv
module wls_first_pend #(
  parameter int N   = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/wls_seg_match.sv
module wls_seg_match #(
  parameter int N      = 32,
  parameter int ADDR_W = 32
) (
  input  logic [N-1:0][ADDR_W-1:0] lo_i,
  input  logic [N-1:0][ADDR_W-1:0] hi_i,
  input  logic [N-1:0]             pend_lo_i,
  input  logic [N-1:0]             pend_hi_i,
  input  logic [ADDR_W-1:0]        sel_i,
  output logic [N-1:0]             hit_lo_o,
  output logic [N-1:0]             hit_hi_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign hit_lo_o[g] = pend_lo_i[g] && (lo_i[g] == sel_i);
    assign hit_hi_o[g] = pend_hi_i[g] && (hi_i[g] == sel_i);
  end
endmodule

// File: rtl/warp_line_splitter.sv
module warp_line_splitter #(
  parameter int NUM_LANES = 32,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = $clog2(2 * NUM_LANES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [NUM_LANES*ADDR_W-1:0]   req_addr_i,
  input  logic [NUM_LANES-1:0]          req_mask_i,
  input  logic [2:0]                    req_size_i,
  input  logic                          req_l2only_i,
  input  logic                          req_volatile_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [ADDR_W-1:0]             out_addr_o,
  output logic [7:0]                    out_bytes_o,
  output logic [NUM_LANES-1:0]          out_lanes_o,
  output logic                          out_refetch_o,
  output logic                          done_o,
  output logic [CNT_W-1:0]              done_count_o
);
  import wls_pkg::*;

  localparam int IDX_W = $clog2(NUM_LANES);

  wls_state_e                     state_q;
  logic [NUM_LANES-1:0][ADDR_W-1:0] lo_d, hi_d, lo_q, hi_q;
  logic [NUM_LANES-1:0]           pend_lo_q, pend_hi_q, straddle;
  logic [NUM_LANES-1:0]           hit_lo, hit_hi;
  logic                           l2_q, vol_q;
  logic [CNT_W-1:0]               cnt_q;
  logic [IDX_W-1:0]               sel_idx;
  logic                           any_pend;
  logic [ADDR_W-1:0]              sel_addr;
  logic                           accept, fire;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_span
    wls_lane_span #(.ADDR_W(ADDR_W)) u_span (
      .addr_i   (req_addr_i[g*ADDR_W +: ADDR_W]),
      .size_i   (req_size_i),
      .l2only_i (req_l2only_i),
      .lo_o     (lo_d[g]),
      .hi_o     (hi_d[g])
    );
    assign straddle[g] = lo_d[g] != hi_d[g];
  end

  wls_first_pend #(.N(NUM_LANES), .IDX_W(IDX_W)) u_first (
    .pend_i (pend_lo_q | pend_hi_q),
    .idx_o  (sel_idx),
    .any_o  (any_pend)
  );

  // lower unit of the lowest pending lane goes first
  assign sel_addr = pend_lo_q[sel_idx] ? lo_q[sel_idx] : hi_q[sel_idx];

  wls_seg_match #(.N(NUM_LANES), .ADDR_W(ADDR_W)) u_match (
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .pend_lo_i (pend_lo_q),
    .pend_hi_i (pend_hi_q),
    .sel_i     (sel_addr),
    .hit_lo_o  (hit_lo),
    .hit_hi_o  (hit_hi)
  );

  assign req_ready_o   = state_q == ST_IDLE;
  assign accept        = req_valid_i && req_ready_o;
  assign out_valid_o   = (state_q == ST_RUN) && any_pend;
  assign fire          = out_valid_o && out_ready_i;
  assign out_addr_o    = sel_addr;
  assign out_lanes_o   = hit_lo | hit_hi;
  assign out_bytes_o   = l2_q ? 8'd32 : 8'd128;
  assign out_refetch_o = vol_q;
  assign done_o        = state_q == ST_DONE;
  assign done_count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      pend_lo_q <= '0;
      pend_hi_q <= '0;
      l2_q      <= 1'b0;
      vol_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_RUN;
          lo_q      <= lo_d;
          hi_q      <= hi_d;
          pend_lo_q <= req_mask_i;
          pend_hi_q <= req_mask_i & straddle;
          l2_q      <= req_l2only_i;
          vol_q     <= req_volatile_i;
          cnt_q     <= '0;
        end
        ST_RUN: begin
          if (!any_pend) state_q <= ST_DONE;
          if (fire) begin
            pend_lo_q <= pend_lo_q & ~hit_lo;
            pend_hi_q <= pend_hi_q & ~hit_hi;
            cnt_q     <= cnt_q + CNT_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_lanes_o) && $stable(out_bytes_o));

  // R4
  lanes_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_lanes_o != '0);

  // R2 R3
  unit_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_addr_o & (ADDR_W'(out_bytes_o) - ADDR_W'(1))) == '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  // R10
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) && fire |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: tb/warp_line_splitter_bench.sv
module warp_line_splitter_bench;
  localparam int NL = 32;
  localparam int AW = 32;
  localparam int CW = $clog2(2 * NL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [NL*AW-1:0]  req_addr = '0;
  logic [NL-1:0]     req_mask = '0;
  logic [2:0]        req_size = '0;
  logic              req_l2 = 1'b0, req_vol = 1'b0;
  logic              out_valid, out_ready = 1'b0, out_refetch, done;
  logic [AW-1:0]     out_addr;
  logic [7:0]        out_bytes;
  logic [NL-1:0]     out_lanes;
  logic [CW-1:0]     done_count;

  warp_line_splitter #(.NUM_LANES(NL), .ADDR_W(AW)) u_warp_line_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .req_size_i(req_size),
    .req_l2only_i(req_l2), .req_volatile_i(req_vol),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_addr_o(out_addr), .out_bytes_o(out_bytes), .out_lanes_o(out_lanes),
    .out_refetch_o(out_refetch), .done_o(done), .done_count_o(done_count)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [2:0]  sz;
    logic        l2;
    logic        vol;
    logic        rev;
    logic        bp;
    logic [31:0] mask;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'd4,    3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R2
    '{32'h1000, 32'd4,    3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R3 R5
    '{32'h2000, 32'd4,    3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF}, // R4 R7 R11
    '{32'h2104, 32'd0,    3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R4 R6
    '{32'h3000, 32'd256,  3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF}, // R9 R11
    '{32'h407E, 32'd64,   3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R8
    '{32'h5001, 32'd1,    3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAAAA_5555}, // R12
    '{32'h6008, 32'd16,   3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 32'hF0F0_0F0F}, // R8 R12
    '{32'h707C, 32'd1000, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF}  // R8 R12
  };

  int total = 0, bad = 0;
  logic [AW-1:0] exp_addr [64];
  logic [NL-1:0] exp_mask [64];
  int            exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] lane_addr(input vec_t v, input int i);
    int k;
    k = v.rev ? (NL - 1 - i) : i;
    return v.base + v.stride * k;
  endfunction

  // independent model: walk lanes, lower unit then upper, skip units already listed
  task automatic build_exp(input vec_t v);
    logic [AW-1:0] lo [NL];
    logic [AW-1:0] hi [NL];
    int nb, ub;
    nb = 1 << ((v.sz > 3'd4) ? 4 : int'(v.sz));
    ub = v.l2 ? 32 : 128;
    exp_n = 0;
    for (int i = 0; i < NL; i++) begin
      lo[i] = (lane_addr(v, i) / ub) * ub;
      hi[i] = ((lane_addr(v, i) + nb - 1) / ub) * ub;
    end
    for (int i = 0; i < NL; i++) begin
      if (v.mask[i]) begin
        for (int s = 0; s < 2; s++) begin
          logic [AW-1:0] u;
          bit seen;
          u = (s == 0) ? lo[i] : hi[i];
          seen = 1'b0;
          for (int e = 0; e < exp_n; e++) if (exp_addr[e] == u) seen = 1'b1;
          if (!seen) begin
            exp_addr[exp_n] = u;
            exp_mask[exp_n] = '0;
            for (int j = 0; j < NL; j++)
              if (v.mask[j] && (lo[j] == u || hi[j] == u)) exp_mask[exp_n][j] = 1'b1;
            exp_n++;
          end
        end
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    int k, cyc;
    bit stalled, busy_ok;
    logic [AW-1:0] p_addr;
    logic [NL-1:0] p_lanes;
    build_exp(v);
    @(negedge clk);
    for (int i = 0; i < NL; i++) req_addr[i*AW +: AW] = lane_addr(v, i);
    req_mask = v.mask; req_size = v.sz; req_l2 = v.l2; req_vol = v.vol;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0; stalled = 1'b0; busy_ok = 1'b1;
    forever begin
      cyc++;
      if (cyc > 2000) begin
        chk(1'b0, "R10", "watchdog", 64'(cyc), 64'd0);
        break;
      end
      if (done) begin
        chk(done_count == CW'(exp_n), "R10", "done count", 64'(done_count), 64'(exp_n));
        chk(k == exp_n, "R4", "requests seen", 64'(k), 64'(exp_n));
        break;
      end
      if (req_ready) busy_ok = 1'b0;
      out_ready = v.bp ? cyc[0] : 1'b1;
      if (stalled)
        chk(out_valid && out_addr == p_addr && out_lanes == p_lanes, "R11", "hold",
            64'(out_addr), 64'(p_addr));
      if (out_valid) begin
        chk(out_bytes == (v.l2 ? 8'd32 : 8'd128), v.l2 ? "R3" : "R2", "unit bytes",
            64'(out_bytes), v.l2 ? 64'd32 : 64'd128);
        chk(out_refetch == v.vol, "R6", "refetch", 64'(out_refetch), 64'(v.vol));
        if (out_ready) begin
          if (k < exp_n) begin
            chk(out_addr == exp_addr[k], "R7", "unit address", 64'(out_addr), 64'(exp_addr[k]));
            chk(out_lanes == exp_mask[k], "R4", "lane mask", 64'(out_lanes), 64'(exp_mask[k]));
          end else begin
            chk(1'b0, "R4", "extra request", 64'(out_addr), 64'd0);
          end
          k++;
        end
      end
      stalled = out_valid && !out_ready;
      p_addr = out_addr; p_lanes = out_lanes;
      @(negedge clk);
    end
    chk(busy_ok, "R12", "ready low while busy", 64'(busy_ok), 64'd1);
    @(negedge clk);
    chk(!done && req_ready, "R10", "done single cycle", 64'({done, req_ready}), 64'b01);
    out_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R10", "global watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t z;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !out_valid && !done, "R1", "reset state",
        64'({req_ready, out_valid, done}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid && !done, "R1", "after release",
        64'({req_ready, out_valid, done}), 64'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: all lanes off
    z = '{32'h8000, 32'd4, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0};
    run_vec(z);
    // R5: mode flips back to lines right after sectors
    z = '{32'h9040, 32'd8, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF};
    run_vec(z);
    z.l2 = 1'b0;
    run_vec(z);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule